// File: doc/BRIEF.md
# Integer Execute Unit with Set-Compare

This is the combinational execute stage of a small 32-bit load/store processor core. Each cycle it takes two register operands, a 6-bit function code, a 16-bit immediate and a flag that selects the immediate as the second operand. It returns a 32-bit result and a signed-overflow trap flag in the same cycle. It has no internal state. The pipeline registers around it belong to the surrounding core.

The unit covers wrapping add and subtract, the three bitwise logic operations, and logical and arithmetic shifts. It also has six relational tests that write 0 or 1, and a load-upper operation that places the immediate in the high half of the word. When the immediate path is selected, the unit widens the immediate in one of two ways. Arithmetic and compare operations get a sign-extended immediate. The bitwise operations get a zero-extended one. Function codes the unit does not recognise give an all-zero result and never raise the trap.

Top module: `alu_exec_unit`

## Requirements
- R1: Function code 000100 returns the sum of operand A and operand B, modulo 2^32.
- R2: Function code 000110 returns operand A minus operand B, modulo 2^32.
- R3: `ovf_trap` is 1 only for codes 000100 and 000110, and only when the true signed result falls outside the 32-bit two's-complement range. It is 0 for every other code.
- R4: Codes 001000, 001001 and 001010 return the bitwise AND, OR and XOR of the operands.
- R5: Codes 001100 (left) and 001110 (logical right) shift operand A by the value in bits [4:0] of operand B and fill the vacated bits with zeros. The upper bits of the shift amount are ignored.
- R6: Code 001111 shifts operand A right by bits [4:0] of operand B and fills the vacated bits with copies of bit 31 of A.
- R7: Codes 010000 (equal) and 010010 (not equal) return 32'h1 when the relation holds and 32'h0 when it does not.
- R8: Codes 010100 (less), 010110 (less or equal), 011000 (greater) and 011010 (greater or equal) compare the operands as signed two's-complement values and return 32'h1 or 32'h0.
- R9: When `imm_sel` is 1, operand B is replaced by the immediate sign-extended to 32 bits. This applies to add, subtract and all six compares.
- R10: When `imm_sel` is 1, the logic codes use the immediate zero-extended to 32 bits. The shift codes use bits [4:0] of the immediate.
- R11: Code 011011 returns the immediate in bits [31:16] and zeros in bits [15:0]. It ignores operand A, operand B and `imm_sel`.
- R12: Code 000000 and every code not listed above return 32'h0 with `ovf_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand (register form) |
| func_code | input | 6 | Operation select |
| imm_val | input | 16 | Immediate field |
| imm_sel | input | 1 | 1 = use the widened immediate in place of operand B |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on add or subtract |

## Verification
The unit holds no state, so any decode or datapath fault shows at `result` or `ovf_trap` in the same cycle as the offending code and operands. The only way to observe it is to apply the right combination of inputs. The sweep therefore crosses every one of the 64 function codes with operands chosen to sit at the sign boundaries, with shift amounts above 31, and with immediates whose bit 15 is set. Some faults are only visible there: a swapped extension mode, a wrong fill bit, or a compare derived from an unsigned borrow. A fault that affects only a few operand pairs is caught by the additional random pairs, which are checked against the bench's own arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [5:0] {
        FN_NOP  = 6'b000000,
        FN_ADD  = 6'b000100,
        FN_SUB  = 6'b000110,
        FN_AND  = 6'b001000,
        FN_OR   = 6'b001001,
        FN_XOR  = 6'b001010,
        FN_SLL  = 6'b001100,
        FN_SRL  = 6'b001110,
        FN_SRA  = 6'b001111,
        FN_SEQ  = 6'b010000,
        FN_SNE  = 6'b010010,
        FN_SLT  = 6'b010100,
        FN_SLE  = 6'b010110,
        FN_SGT  = 6'b011000,
        FN_SGE  = 6'b011010,
        FN_LDHI = 6'b011011
    } alu_fn_e;

    typedef enum logic [2:0] {
        K_NONE, K_ARITH, K_LOGIC, K_SHIFT, K_CMP, K_LDHI
    } op_kind_e;

    typedef enum logic [1:0] {
        LG_AND, LG_OR, LG_XOR
    } logic_op_e;

    typedef enum logic [2:0] {
        REL_EQ, REL_NE, REL_LT, REL_LE, REL_GT, REL_GE
    } rel_e;

    typedef struct packed {
        op_kind_e  kind;
        logic      sub;
        logic_op_e lop;
        logic      sh_right;
        logic      sh_arith;
        rel_e      rel;
        logic      imm_sext;
    } alu_dec_t;

    function automatic alu_dec_t alu_decode(input logic [5:0] fn);
        alu_dec_t d;
        d = '{kind: K_NONE, sub: 1'b0, lop: LG_AND, sh_right: 1'b0,
              sh_arith: 1'b0, rel: REL_EQ, imm_sext: 1'b0};
        case (fn)
            FN_ADD:  begin d.kind = K_ARITH; d.imm_sext = 1'b1; end
            FN_SUB:  begin d.kind = K_ARITH; d.sub = 1'b1; d.imm_sext = 1'b1; end
            FN_AND:  begin d.kind = K_LOGIC; d.lop = LG_AND; end
            FN_OR:   begin d.kind = K_LOGIC; d.lop = LG_OR;  end
            FN_XOR:  begin d.kind = K_LOGIC; d.lop = LG_XOR; end
            FN_SLL:  d.kind = K_SHIFT;
            FN_SRL:  begin d.kind = K_SHIFT; d.sh_right = 1'b1; end
            FN_SRA:  begin d.kind = K_SHIFT; d.sh_right = 1'b1; d.sh_arith = 1'b1; end
            FN_SEQ:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_EQ; end
            FN_SNE:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_NE; end
            FN_SLT:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_LT; end
            FN_SLE:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_LE; end
            FN_SGT:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_GT; end
            FN_SGE:  begin d.kind = K_CMP; d.sub = 1'b1; d.imm_sext = 1'b1; d.rel = REL_GE; end
            FN_LDHI: d.kind = K_LDHI;
            default: d.kind = K_NONE;
        endcase
        return d;
    endfunction

    function automatic logic rel_holds(input rel_e r, input logic lt, input logic eq);
        logic h;
        case (r)
            REL_EQ:  h = eq;
            REL_NE:  h = !eq;
            REL_LT:  h = lt;
            REL_LE:  h = lt | eq;
            REL_GT:  h = !(lt | eq);
            REL_GE:  h = !lt;
            default: h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             sext,
    output logic [XLEN-1:0]  b_eff
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_wide;

    assign imm_wide = {{PAD_W{imm[IMM_W-1] & sext}}, imm};
    assign b_eff    = use_imm ? imm_wide : reg_b;

    // R10: a zero-extended immediate never carries bits above the field
    always_comb begin
        if (use_imm && !sext)
            a_r10_zext_upper: assert (b_eff[XLEN-1:IMM_W] == '0);
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            do_sub,
    output logic [XLEN-1:0] sum,
    output logic            ovf,
    output logic            lt,
    output logic            eq
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_x;

    assign b_x = do_sub ? ~b : b;
    assign sum = a + b_x + {{(XLEN-1){1'b0}}, do_sub};
    assign ovf = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);
    assign lt  = sum[MSB] ^ ovf;
    assign eq  = (a == b);

    // R8: signed less-than and equality cannot both hold
    always_comb begin
        if (do_sub)
            a_r8_lt_eq_exclusive: assert (!(lt && eq));
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         data,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    right,
    input  logic                    arith,
    output logic [XLEN-1:0]         out
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] stg_l [0:SHW];
    logic [XLEN-1:0] stg_r [0:SHW];
    logic            fill;

    assign fill     = arith & data[XLEN-1];
    assign stg_l[0] = data;
    assign stg_r[0] = data;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int SH = 1 << i;
        assign stg_l[i+1] = amt[i] ? {stg_l[i][XLEN-1-SH:0], {SH{1'b0}}} : stg_l[i];
        assign stg_r[i+1] = amt[i] ? {{SH{fill}}, stg_r[i][XLEN-1:SH]}   : stg_r[i];
    end

    assign out = right ? stg_r[SHW] : stg_l[SHW];

    // R5: a zero shift amount passes the operand unchanged
    always_comb begin
        if (amt == '0)
            a_r5_amt_zero_pass: assert (out == data);
    end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [5:0]       func_code,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             imm_sel,
    output logic [XLEN-1:0]  result,
    output logic             ovf_trap
);
    localparam int SHW   = $clog2(XLEN);
    localparam int LOW_W = XLEN - IMM_W;

    alu_dec_t        dec;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] sh_out;
    logic            as_ovf;
    logic            lt;
    logic            eq;

    assign dec = alu_decode(func_code);

    alu_opnd_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
        .reg_b   (opnd_b),
        .imm     (imm_val),
        .use_imm (imm_sel),
        .sext    (dec.imm_sext),
        .b_eff   (b_eff)
    );

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a      (opnd_a),
        .b      (b_eff),
        .do_sub (dec.sub),
        .sum    (sum),
        .ovf    (as_ovf),
        .lt     (lt),
        .eq     (eq)
    );

    alu_shifter #(.XLEN(XLEN)) u_shift (
        .data  (opnd_a),
        .amt   (b_eff[SHW-1:0]),
        .right (dec.sh_right),
        .arith (dec.sh_arith),
        .out   (sh_out)
    );

    always_comb begin
        result   = '0;
        ovf_trap = 1'b0;
        case (dec.kind)
            K_ARITH: begin
                result   = sum;
                ovf_trap = as_ovf;
            end
            K_LOGIC: begin
                case (dec.lop)
                    LG_AND:  result = opnd_a & b_eff;
                    LG_OR:   result = opnd_a | b_eff;
                    LG_XOR:  result = opnd_a ^ b_eff;
                    default: result = '0;
                endcase
            end
            K_SHIFT: result = sh_out;
            K_CMP:   result = {{(XLEN-1){1'b0}}, rel_holds(dec.rel, lt, eq)};
            K_LDHI:  result = {imm_val, {LOW_W{1'b0}}};
            default: result = '0;
        endcase
    end

    always_comb begin
        // R3: the trap only ever accompanies add or subtract
        if (ovf_trap)
            a_r3_ovf_arith_only: assert (func_code == FN_ADD || func_code == FN_SUB);
        // R7 / R8: compares produce a single-bit value
        if (dec.kind == K_CMP)
            a_r7_cmp_boolean: assert (result[XLEN-1:1] == '0);
        // R11: load-upper leaves the low half clear
        if (func_code == FN_LDHI)
            a_r11_low_clear: assert (result[LOW_W-1:0] == '0);
        // R12: idle and unknown codes are silent
        if (dec.kind == K_NONE)
            a_r12_idle_silent: assert (result == '0 && !ovf_trap);
    end
endmodule

// File: tb/sim_alu_exec_unit.sv
`timescale 1ns/1ps
module sim_alu_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [5:0]  fn;
    logic [15:0] imm;
    logic        sel;
    logic [31:0] res;
    logic        ovf;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    alu_exec_unit u0 (
        .opnd_a    (a),
        .opnd_b    (b),
        .func_code (fn),
        .imm_val   (imm),
        .imm_sel   (sel),
        .result    (res),
        .ovf_trap  (ovf)
    );

    function automatic bit is_logic(input logic [5:0] f);
        return f == 6'b001000 || f == 6'b001001 || f == 6'b001010;
    endfunction

    function automatic string tag_of(input logic [5:0] f, input logic s);
        string t;
        case (f)
            6'b000100: t = "R1";
            6'b000110: t = "R2";
            6'b001000, 6'b001001, 6'b001010: t = "R4";
            6'b001100, 6'b001110: t = "R5";
            6'b001111: t = "R6";
            6'b010000, 6'b010010: t = "R7";
            6'b010100, 6'b010110, 6'b011000, 6'b011010: t = "R8";
            6'b011011: t = "R11";
            default: t = "R12";
        endcase
        if (s && t != "R11" && t != "R12")
            t = {t, (is_logic(f) || t == "R5" || t == "R6") ? "/R10" : "/R9"};
        return t;
    endfunction

    task automatic model(input logic [31:0] ma, input logic [31:0] mb,
                         input logic [5:0] mf, input logic [15:0] mi,
                         input logic ms, output logic [31:0] r, output logic v);
        logic [31:0] bb;
        bb = ms ? (is_logic(mf) ? {16'h0, mi} : {{16{mi[15]}}, mi}) : mb;
        r = 32'h0;
        v = 1'b0;
        case (mf)
            6'b000100: begin r = ma + bb; v = (ma[31] == bb[31]) && (r[31] != ma[31]); end
            6'b000110: begin r = ma - bb; v = (ma[31] != bb[31]) && (r[31] != ma[31]); end
            6'b001000: r = ma & bb;
            6'b001001: r = ma | bb;
            6'b001010: r = ma ^ bb;
            6'b001100: r = ma << bb[4:0];
            6'b001110: r = ma >> bb[4:0];
            6'b001111: r = $unsigned($signed(ma) >>> bb[4:0]);
            6'b010000: r = {31'h0, ma == bb};
            6'b010010: r = {31'h0, ma != bb};
            6'b010100: r = {31'h0, $signed(ma) <  $signed(bb)};
            6'b010110: r = {31'h0, $signed(ma) <= $signed(bb)};
            6'b011000: r = {31'h0, $signed(ma) >  $signed(bb)};
            6'b011010: r = {31'h0, $signed(ma) >= $signed(bb)};
            6'b011011: r = {mi, 16'h0};
            default: r = 32'h0;
        endcase
    endtask

    task automatic run(input logic [31:0] ta, input logic [31:0] tb_,
                       input logic [5:0] tf, input logic [15:0] ti, input logic ts);
        logic [31:0] er;
        logic        ev;
        @(negedge clk);
        a = ta; b = tb_; fn = tf; imm = ti; sel = ts;
        #5;
        model(ta, tb_, tf, ti, ts, er, ev);
        total++;
        if (res !== er) begin
            bad++;
            $display("FAIL %s fn=%b a=%h b=%h imm=%h sel=%0d result actual=%h expected=%h",
                     tag_of(tf, ts), tf, ta, tb_, ti, ts, res, er);
        end
        total++;
        if (ovf !== ev) begin
            bad++;
            $display("FAIL R3 fn=%b a=%h b=%h imm=%h sel=%0d ovf actual=%0d expected=%0d",
                     tf, ta, tb_, ti, ts, ovf, ev);
        end
    endtask

    logic [31:0] ops [0:11];
    logic [15:0] imms [0:7];

    initial begin
        ops[0] = 32'h0000_0000; ops[1]  = 32'h0000_0001; ops[2]  = 32'h0000_0002;
        ops[3] = 32'h7fff_ffff; ops[4]  = 32'h8000_0000; ops[5]  = 32'hffff_ffff;
        ops[6] = 32'h0000_001f; ops[7]  = 32'h0000_0020; ops[8]  = 32'h1234_5678;
        ops[9] = 32'hedcb_a987; ops[10] = 32'h0000_7fff; ops[11] = 32'hffff_8000;
        imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h7fff; imms[3] = 16'h8000;
        imms[4] = 16'hffff; imms[5] = 16'h001f; imms[6] = 16'h1234; imms[7] = 16'ha5c3;

        a = '0; b = '0; fn = '0; imm = '0; sel = 1'b0;
        repeat (3) @(posedge clk);
        // R12: idle inputs during reset give a zero result and no trap
        #1;
        total++;
        if (res !== 32'h0 || ovf !== 1'b0) begin
            bad++;
            $display("FAIL R12 reset-state actual=%h/%0d expected=00000000/0", res, ovf);
        end
        rst = 1'b0;

        // Directed corners: R3 overflow edges, R6 sign fill, R11 ignores operands
        run(32'h7fff_ffff, 32'h1, 6'b000100, 16'h0, 1'b0);
        run(32'h8000_0000, 32'h1, 6'b000110, 16'h0, 1'b0);
        run(32'h8000_0000, 32'h0, 6'b001111, 16'h001f, 1'b1);
        run(32'hdead_beef, 32'hffff_ffff, 6'b011011, 16'hbeef, 1'b0);
        run(32'h0000_0005, 32'hffff_ffe3, 6'b001100, 16'h0, 1'b0);

        // Exhaustive over function codes, corner operands and immediates
        for (int f = 0; f < 64; f++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++)
                    run(ops[i], ops[j], 6'(f), imms[j % 8], 1'b0);
                for (int k = 0; k < 8; k++)
                    run(ops[i], ops[(i + k) % 12], 6'(f), imms[k], 1'b1);
            end
        end

        // Random operand pairs across all codes
        for (int n = 0; n < 3000; n++)
            run($urandom, $urandom, 6'($urandom), 16'($urandom), 1'($urandom));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule